// File: doc/BRIEF.md
# Zero-Suppressing Column Readout Chain

This block serialises the per-channel frame words of one pixel column after an acquisition. Every channel cell holds one record made of a hit flag, an arrival-time count, a time-over-threshold count and a pattern of which sub-elements fired. On a load strobe the records of all cells are captured in parallel. The cells are then joined as one long shift register and moved out one bit per readout clock cycle, cell 0 first.

With compression on, a cell whose hit flag is clear gives only its flag bit. Its other bits are never shifted, and the next cell's record follows in the very next cycle. With compression off, every cell gives its full record. A frame-active output brackets the transmitted bits. A forwarded clock runs only while the frame is active, so that a receiver can sample each bit at the middle of its cycle. A one-cycle done pulse marks the end of the transfer.

Top module: `column_readout`

## Requirements
- R1: A high `load_i` while the chain is idle captures every cell word from `frames_i`, with cell c taken from bits [c*22+21 : c*22]. In the cycle after the capturing edge, `frame_o` is high and the first bit is on `ser_data_o`.
- R2: A record is sent MSB first, in this order: word bit 21 (hit flag), bits 20..13 (arrival time), bits 12..8 (time over threshold), bits 7..0 (hit pattern). Cell 0 is sent first, then cells in ascending index.
- R3: With compression off, every cell sends all 22 bits, whatever its flag is. A full column takes NUM_CELLS*22 cycles.
- R4: With compression on, a cell whose bit 21 is 0 sends a single 0 bit. The first bit of the next cell appears in the next cycle.
- R5: With compression on, a cell whose bit 21 is 1 sends all 22 bits.
- R6: `frame_o` is high from the first transmitted bit through the last bit of the last cell, and low otherwise. `ser_data_o` is 0 whenever `frame_o` is low.
- R7: `done_o` is high for exactly one cycle, the cycle right after the last bit. It is low at all other times.
- R8: `ser_clk_o` equals the inverted `clk` while `frame_o` is high, and is 0 while `frame_o` is low.
- R9: A `load_i` pulse while a transfer is under way or `done_o` is high is ignored. The stream already in flight is unchanged.
- R10: `compress_i` is sampled only on the capturing edge. Changes during a transfer have no effect on it.
- R11: After reset the chain is idle, with `frame_o`, `done_o`, `ser_data_o` and `ser_clk_o` all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Parallel capture strobe, taken only when idle |
| compress_i | input | 1 | Zero-suppression enable, sampled at capture |
| frames_i | input | NUM_CELLS*22 | Flattened cell words, cell 0 in the lowest bits |
| ser_data_o | output | 1 | Serial data, one bit per clock |
| ser_clk_o | output | 1 | Forwarded clock, active only while framing |
| frame_o | output | 1 | High while transmitted bits are valid |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest situations to reach from the ports are those where the inputs move while a transfer is in flight. One is a second load strobe, which would otherwise reset the chain. The other is a change of compression mode combined with new words on `frames_i`. The stimulus raises these inputs in the middle of a compressed transfer and again in the done cycle, and the cycle-accurate model must show the original stream going on untouched. Column patterns with empty first and last cells, all-empty columns and all-hit columns drive the skip logic at its edges. In these columns a single-bit record is followed at once by another one, or ends the frame.

// File: rtl/colro_pkg.sv
package colro_pkg;
    localparam int FLAG_W = 1;
    localparam int TOA_W  = 8;
    localparam int TOT_W  = 5;
    localparam int PAT_W  = 8;
    localparam int REC_W  = FLAG_W + TOA_W + TOT_W + PAT_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } ro_state_e;
endpackage

// File: rtl/readout_cell.sv
module readout_cell #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_word_i,
    input  logic         shift_i,
    input  logic         advance_i,
    input  logic [W-1:0] next_word_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) begin
            word_d = load_word_i;
        end else if (advance_i) begin
            word_d = next_word_i;
        end else if (shift_i) begin
            word_d = {word_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
    import colro_pkg::*;
#(
    parameter int NUM_CELLS = 16,
    parameter int W         = REC_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic compress_i,
    input  logic head_bit_i,
    output logic load_o,
    output logic shift_o,
    output logic advance_o,
    output logic frame_o,
    output logic done_o
);
    localparam int BW = $clog2(W);
    localparam int CW = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;

    typedef struct packed {
        ro_state_e     state;
        logic [BW-1:0] bit_cnt;
        logic [CW-1:0] cell_cnt;
        logic          compress;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  last_bit;

    always_comb begin
        s_d       = s_q;
        load_o    = 1'b0;
        shift_o   = 1'b0;
        advance_o = 1'b0;
        last_bit  = (s_q.bit_cnt == BW'(W - 1)) ||
                    (s_q.compress && (s_q.bit_cnt == '0) && !head_bit_i);
        case (s_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    load_o       = 1'b1;
                    s_d.state    = ST_SHIFT;
                    s_d.bit_cnt  = '0;
                    s_d.cell_cnt = '0;
                    s_d.compress = compress_i;
                end
            end
            ST_SHIFT: begin
                if (last_bit) begin
                    advance_o   = 1'b1;
                    s_d.bit_cnt = '0;
                    if (s_q.cell_cnt == CW'(NUM_CELLS - 1)) begin
                        s_d.state = ST_DONE;
                    end else begin
                        s_d.cell_cnt = s_q.cell_cnt + 1'b1;
                    end
                end else begin
                    shift_o     = 1'b1;
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                end
            end
            ST_DONE: begin
                s_d.state = ST_IDLE;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state    <= ST_IDLE;
            s_q.bit_cnt  <= '0;
            s_q.cell_cnt <= '0;
            s_q.compress <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_o = (s_q.state == ST_SHIFT);
    assign done_o  = (s_q.state == ST_DONE);

    AST_FRAME_STARTS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> $past(load_i)); // R1
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> (s_q.bit_cnt < BW'(W))); // R3
    AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o && s_q.compress && (s_q.bit_cnt == '0) && !head_bit_i)
        |=> (s_q.bit_cnt == '0)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(frame_o)); // R7
    AST_LOAD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o || done_o) |-> !load_o); // R9
    AST_COMPRESS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o && $past(frame_o)) |-> $stable(s_q.compress)); // R10
endmodule

// File: rtl/column_readout.sv
module column_readout
    import colro_pkg::*;
#(
    parameter int NUM_CELLS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic                       compress_i,
    input  logic [NUM_CELLS*REC_W-1:0] frames_i,
    output logic                       ser_data_o,
    output logic                       ser_clk_o,
    output logic                       frame_o,
    output logic                       done_o
);
    localparam int W = REC_W;

    logic [W-1:0] words [NUM_CELLS];
    logic         cell_load, cell_shift, cell_adv;
    logic         frame_int, done_int;

    readout_ctrl #(
        .NUM_CELLS (NUM_CELLS),
        .W         (W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .compress_i (compress_i),
        .head_bit_i (words[0][W-1]),
        .load_o     (cell_load),
        .shift_o    (cell_shift),
        .advance_o  (cell_adv),
        .frame_o    (frame_int),
        .done_o     (done_int)
    );

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        logic [W-1:0] nxt;
        if (c == NUM_CELLS - 1) begin : g_tail
            assign nxt = '0;
        end else begin : g_link
            assign nxt = words[c+1];
        end
        readout_cell #(
            .W (W)
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (cell_load),
            .load_word_i (frames_i[c*W +: W]),
            .shift_i     (cell_shift && (c == 0)),
            .advance_i   (cell_adv),
            .next_word_i (nxt),
            .word_o      (words[c])
        );
    end

    assign frame_o    = frame_int;
    assign done_o     = done_int;
    assign ser_data_o = frame_int & words[0][W-1];
    assign ser_clk_o  = frame_int & ~clk;

    AST_CHAIN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done_int |-> (words[0] == '0)); // R2
endmodule

// File: tb/column_readout_tb.sv
`timescale 1ns/100ps
module column_readout_tb;
    localparam int N = 16;
    localparam int W = 22;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic         compress_i = 1'b0;
    logic [N*W-1:0] frames_i = '0;
    logic         ser_data_o, ser_clk_o, frame_o, done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    column_readout #(.NUM_CELLS(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .compress_i (compress_i),
        .frames_i   (frames_i),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o),
        .frame_o    (frame_o),
        .done_o     (done_o)
    );

    always #2 clk = ~clk;

    // behavioural reference: 0 idle, 1 sending, 2 done
    int m_state = 0;
    bit m_comp  = 1'b0;
    bit m_bits[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0;
            m_bits.delete();
        end else begin
            cycles++;
            case (m_state)
                0: if (load_i) begin // R1, R10: capture words and mode here only
                    m_comp = compress_i;
                    m_bits.delete();
                    for (int c = 0; c < N; c++) begin
                        logic [W-1:0] w;
                        w = frames_i[c*W +: W];
                        if (m_comp && !w[W-1]) m_bits.push_back(1'b0);
                        else for (int b = W-1; b >= 0; b--) m_bits.push_back(w[b]);
                    end
                    m_state = 1;
                end
                1: begin
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) m_state = 2;
                end
                default: m_state = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        #0.5;
        begin
            logic ef, ed, ex;
            ef = (m_state == 1);
            ed = (m_state == 2);
            ex = ef ? m_bits[0] : 1'b0;
            chk("R6 R11 frame", frame_o, ef);
            chk("R7 R11 done", done_o, ed);
            chk("R8 R11 ser_clk", ser_clk_o, ef);
            chk(m_comp ? "R2 R4 R5 R9 data" : "R2 R3 R9 data", ser_data_o, ex);
        end
    end

    function automatic logic [W-1:0] mk(input bit hit);
        logic [W-1:0] w;
        w = W'($urandom);
        w[W-1] = hit;
        return w;
    endfunction

    task automatic start(input bit comp);
        @(negedge clk);
        compress_i = comp;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; // R11 checked by the compare loop while idle
        repeat (2) @(negedge clk);

        // R3: mixed words, compression off
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk($urandom_range(0, 1));
        start(1'b0); wait_done();
        // R4 R5: mixed words, compression on
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk($urandom_range(0, 1));
        start(1'b1); wait_done();
        // R4: all empty, garbage in the other bits
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk(1'b0);
        start(1'b1); wait_done();
        // R5: all hit
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk(1'b1);
        start(1'b1); wait_done();
        // R4: empty first and last cells, alternating inside
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk((c % 2) == 1 && c != N-1);
        start(1'b1); wait_done();
        // R3: all empty without compression
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk(1'b0);
        start(1'b0); wait_done();
        // R9 R10: pokes while busy and in the done cycle
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk($urandom_range(0, 1));
        start(1'b1);
        repeat (5) @(negedge clk);
        compress_i = 1'b0;
        for (int c = 0; c < N; c++) frames_i[c*W +: W] = mk(1'b1);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        while (!done_o) @(negedge clk);
        load_i = 1'b1; // sampled in the done cycle: ignored (R9)
        @(negedge clk);
        load_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: a normal start after the ignored pokes
        start(1'b1); wait_done();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        while (cycles < 150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule